// File: doc/BRIEF.md
# CAN Receive Mailbox Matching Engine

This block decides where a received CAN frame goes. The protocol engine supplies the frame's identifier with its IDE and RTR bits, together with the frame-phase strobes: a level that is high while the CRC field is being received, an end-of-frame activity flag with a bit index, and a protocol error pulse. When the CRC field begins, the identifier is captured into a staging register that software cannot address. While the CRC field is received, a state machine walks the candidate destinations one per clock. It first visits an optional table of eight FIFO acceptance filters, then the receive mailboxes. The search stops at the first entry that accepts the frame.

The copy into the chosen destination is called move-in. It is held back until the sixth end-of-frame bit. A protocol error seen earlier cancels it. Move-in appears as a one-cycle strobe carrying the destination and the received identifier. It sets the winning mailbox's interrupt flag or adds a frame to the FIFO occupancy. Clearing the frames-available flag releases the FIFO entry that is currently exposed. Frames the node sent itself can be suppressed completely.

States:
- `ST_IDLE`: waits for the CRC field to start.
- `ST_SCAN`: visits one candidate per clock.
- `ST_WAIT`: holds the result until the commit bit arrives, or an error cancels it.
- `ST_COMMIT`: the one-cycle move-in.

Transitions:
- IDLE→SCAN: on the rising edge of the CRC field.
- IDLE→WAIT: on that same edge, for a suppressed self-sent frame.
- SCAN→WAIT: on a hit, or after the last mailbox is visited.
- SCAN→IDLE and WAIT→IDLE: on an error.
- WAIT→COMMIT: at the commit bit, when a hit still stands.
- WAIT→IDLE: at the commit bit, when no hit stands.
- COMMIT→IDLE: always.

Top module: `rxm_router`

## Requirements
- R1: The identifier, IDE and RTR values are captured on the clock where `crc_act_i` rises. Later changes of `rx_id_i` during the same frame do not alter the `movein_id_o` reported for that frame.
- R2: An entry accepts a frame only if all of these hold:
  - its IDE bit equals the frame's IDE bit;
  - its RTR bit equals the frame's RTR bit;
  - the received ID and the entry ID agree on every bit set in the entry mask.
  For standard frames (IDE=0) only ID bits [10:0] take part; for extended frames all 29 bits take part.
- R3: The FIFO table is searched first, entry 0 upward, but only if `fifo_en_i` is high and the FIFO is not full when the search starts. A table hit takes priority over any mailbox hit and is reported with `movein_fifo_o`=1 and the table entry number in `movein_idx_o`.
- R4: If the FIFO is full when the search starts, only mailboxes are searched.
- R5: Among mailboxes whose `mb_en_i` bit is set, the lowest-index accepting mailbox wins. The winner is reported with `movein_fifo_o`=0 and its index in `movein_idx_o`.
- R6: Move-in happens only at the commit bit:
  - `movein_o` is high for exactly one cycle, the cycle after a clock edge that sees `eof_act_i`=1 and `eof_cnt_i`=5 (the sixth end-of-frame bit, counted from 0);
  - `movein_id_o` then carries the received identifier, even when the match came through a mask.
- R7: A high `err_i` at any clock edge after the CRC field starts and up to the commit edge cancels the frame: there is no move-in, no flag and no FIFO change.
- R8: When `self_tx_i` and `self_rx_dis_i` are both high at the start of the CRC field, the frame is neither stored nor flagged. With `self_rx_dis_i` low, a self-sent frame is matched like any other.
- R9: A mailbox whose `mb_en_i` bit is low when the search visits it is skipped. If the winning mailbox's `mb_en_i` bit drops before the commit bit, the frame is lost: there is no move-in, and no other mailbox is tried.
- R10: The flag `mb_flag_o[i]` behaves as follows:
  - it is 0 after reset;
  - it becomes 1 on the cycle after a move-in to mailbox i;
  - it is cleared one cycle after `mb_flag_clr_i[i]` is pulsed.
- R11: The FIFO holds up to FIFO_DEPTH (default 6) frames:
  - `fifo_avail_o` is high while at least one frame is held;
  - `fifo_full_o` is high while FIFO_DEPTH frames are held;
  - a one-cycle `fifo_pop_i` pulse releases one frame;
  - both flags are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_id_i | input | 29 | Received identifier (standard ID in bits [10:0]) |
| rx_ide_i | input | 1 | Received extended-format bit |
| rx_rtr_i | input | 1 | Received remote-request bit |
| self_tx_i | input | 1 | Frame was transmitted by this node |
| self_rx_dis_i | input | 1 | Suppress frames sent by this node |
| crc_act_i | input | 1 | High while the CRC field is received |
| eof_act_i | input | 1 | End-of-frame field in progress |
| eof_cnt_i | input | 3 | Bit index within end-of-frame |
| err_i | input | 1 | Protocol error pulse |
| fifo_en_i | input | 1 | FIFO table enabled |
| fifo_pop_i | input | 1 | Clear frames-available flag, releasing one frame |
| tbl_id_i | input | 8*29 | FIFO filter IDs, entry k at [k*29 +: 29] |
| tbl_mask_i | input | 8*29 | FIFO filter masks |
| tbl_ide_i | input | 8 | FIFO filter IDE bits |
| tbl_rtr_i | input | 8 | FIFO filter RTR bits |
| mb_en_i | input | NUM_MB | Mailbox active for reception |
| mb_id_i | input | NUM_MB*29 | Mailbox IDs |
| mb_mask_i | input | NUM_MB*29 | Mailbox masks |
| mb_ide_i | input | NUM_MB | Mailbox IDE bits |
| mb_rtr_i | input | NUM_MB | Mailbox RTR bits |
| mb_flag_clr_i | input | NUM_MB | Per-mailbox flag clear |
| movein_o | output | 1 | Move-in strobe |
| movein_fifo_o | output | 1 | Destination is the FIFO |
| movein_idx_o | output | IDX_W | Table entry or mailbox index |
| movein_id_o | output | 29 | Received identifier being stored |
| mb_flag_o | output | NUM_MB | Per-mailbox receive flags |
| fifo_avail_o | output | 1 | FIFO holds at least one frame |
| fifo_full_o | output | 1 | FIFO holds FIFO_DEPTH frames |

## Verification
Results are due at fixed offsets from the commit bit:
- `movein_o` and its destination fields are valid one cycle after the edge that sees end-of-frame bit 5.
- Mailbox flags and the FIFO occupancy flags change one edge later.
- A flag clear or a FIFO pop shows one cycle after its pulse.

The bench drives and samples on falling edges. A monitor compares each move-in strobe against the expectation queued by the frame driver, so the result is checked on the very cycle it is due. After each frame the driver waits four more cycles, then checks that the queue is empty and reads the flags. A frame that should vanish is thereby seen to leave no strobe, no flag and no FIFO change.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
    localparam int ID_W  = 29;
    localparam int STD_W = 11;
    localparam int TBL_N = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WAIT,
        ST_COMMIT
    } rxm_state_e;
endpackage

// File: rtl/rxm_id_cmp.sv
module rxm_id_cmp
    import rxm_pkg::*;
(
    input  logic [ID_W-1:0] rx_id,
    input  logic            rx_ide,
    input  logic            rx_rtr,
    input  logic [ID_W-1:0] ent_id,
    input  logic [ID_W-1:0] ent_mask,
    input  logic            ent_ide,
    input  logic            ent_rtr,
    output logic            hit
);
    logic [ID_W-1:0] eff_mask;

    // standard frames compare only the low 11 identifier bits
    always_comb begin
        eff_mask = ent_ide ? ent_mask
                           : {{(ID_W-STD_W){1'b0}}, ent_mask[STD_W-1:0]};
        hit = (ent_ide == rx_ide) && (ent_rtr == rx_rtr)
              && (((rx_id ^ ent_id) & eff_mask) == '0);
    end
endmodule

// File: rtl/rxm_flags.sv
module rxm_flags #(
    parameter int NUM_MB     = 8,
    parameter int FIFO_DEPTH = 6,
    parameter int IDX_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              commit_fifo,
    input  logic [IDX_W-1:0]  commit_idx,
    input  logic              fifo_pop,
    input  logic [NUM_MB-1:0] mb_clr,
    output logic [NUM_MB-1:0] mb_flag,
    output logic              fifo_avail,
    output logic              fifo_full
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FIFO_DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic             push;
    logic             pop;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_flag
        logic set_i;
        assign set_i = commit && !commit_fifo && (commit_idx == IDX_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         mb_flag[i] <= 1'b0;
            else if (set_i)     mb_flag[i] <= 1'b1;
            else if (mb_clr[i]) mb_flag[i] <= 1'b0;
        end
    end

    assign push = commit && commit_fifo;
    assign pop  = fifo_pop && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign fifo_avail = (cnt_q != '0);
    assign fifo_full  = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rxm_router.sv
module rxm_router
    import rxm_pkg::*;
#(
    parameter int NUM_MB       = 8,
    parameter int FIFO_DEPTH   = 6,
    parameter int EOF_MOVE_BIT = 5,
    localparam int SCAN_N      = (NUM_MB > TBL_N) ? NUM_MB : TBL_N,
    localparam int IDX_W       = $clog2(SCAN_N)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ID_W-1:0]        rx_id_i,
    input  logic                   rx_ide_i,
    input  logic                   rx_rtr_i,
    input  logic                   self_tx_i,
    input  logic                   self_rx_dis_i,
    input  logic                   crc_act_i,
    input  logic                   eof_act_i,
    input  logic [2:0]             eof_cnt_i,
    input  logic                   err_i,
    input  logic                   fifo_en_i,
    input  logic                   fifo_pop_i,
    input  logic [TBL_N*ID_W-1:0]  tbl_id_i,
    input  logic [TBL_N*ID_W-1:0]  tbl_mask_i,
    input  logic [TBL_N-1:0]       tbl_ide_i,
    input  logic [TBL_N-1:0]       tbl_rtr_i,
    input  logic [NUM_MB-1:0]      mb_en_i,
    input  logic [NUM_MB*ID_W-1:0] mb_id_i,
    input  logic [NUM_MB*ID_W-1:0] mb_mask_i,
    input  logic [NUM_MB-1:0]      mb_ide_i,
    input  logic [NUM_MB-1:0]      mb_rtr_i,
    input  logic [NUM_MB-1:0]      mb_flag_clr_i,
    output logic                   movein_o,
    output logic                   movein_fifo_o,
    output logic [IDX_W-1:0]       movein_idx_o,
    output logic [ID_W-1:0]        movein_id_o,
    output logic [NUM_MB-1:0]      mb_flag_o,
    output logic                   fifo_avail_o,
    output logic                   fifo_full_o
);
    localparam logic [2:0]       MOVE_CNT = 3'(EOF_MOVE_BIT);
    localparam logic [IDX_W-1:0] TBL_LAST = IDX_W'(TBL_N - 1);
    localparam logic [IDX_W-1:0] MB_LAST  = IDX_W'(NUM_MB - 1);

    rxm_state_e state_q, state_d;

    logic            crc_q;
    logic [ID_W-1:0] stg_id;
    logic            stg_ide, stg_rtr;
    logic            in_fifo;
    logic [IDX_W-1:0] idx;
    logic            hit, hit_fifo;
    logic [IDX_W-1:0] hit_idx;

    logic [SCAN_N-1:0] tbl_cand;
    logic [SCAN_N-1:0] mb_cand;
    logic [SCAN_N-1:0] mb_en_pad;

    logic crc_start, drop_self, cur_hit, last_mb, move_bit, win_gone, commit;

    // acceptance comparators, one per filter entry and per mailbox
    for (genvar k = 0; k < SCAN_N; k++) begin : g_tbl
        if (k < TBL_N) begin : g_on
            rxm_id_cmp u_cmp (
                .rx_id   (stg_id),
                .rx_ide  (stg_ide),
                .rx_rtr  (stg_rtr),
                .ent_id  (tbl_id_i[k*ID_W +: ID_W]),
                .ent_mask(tbl_mask_i[k*ID_W +: ID_W]),
                .ent_ide (tbl_ide_i[k]),
                .ent_rtr (tbl_rtr_i[k]),
                .hit     (tbl_cand[k])
            );
        end else begin : g_off
            assign tbl_cand[k] = 1'b0;
        end
    end

    for (genvar m = 0; m < SCAN_N; m++) begin : g_mb
        if (m < NUM_MB) begin : g_on
            logic acc;
            rxm_id_cmp u_cmp (
                .rx_id   (stg_id),
                .rx_ide  (stg_ide),
                .rx_rtr  (stg_rtr),
                .ent_id  (mb_id_i[m*ID_W +: ID_W]),
                .ent_mask(mb_mask_i[m*ID_W +: ID_W]),
                .ent_ide (mb_ide_i[m]),
                .ent_rtr (mb_rtr_i[m]),
                .hit     (acc)
            );
            assign mb_en_pad[m] = mb_en_i[m];
            assign mb_cand[m]   = acc && mb_en_i[m];
        end else begin : g_off
            assign mb_en_pad[m] = 1'b0;
            assign mb_cand[m]   = 1'b0;
        end
    end

    assign crc_start = crc_act_i && !crc_q;
    assign drop_self = self_tx_i && self_rx_dis_i;
    assign cur_hit   = in_fifo ? tbl_cand[idx] : mb_cand[idx];
    assign last_mb   = !in_fifo && (idx == MB_LAST);
    assign move_bit  = eof_act_i && (eof_cnt_i == MOVE_CNT);
    assign win_gone  = hit && !hit_fifo && !mb_en_pad[hit_idx];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (crc_start) state_d = drop_self ? ST_WAIT : ST_SCAN;
            ST_SCAN:   if (err_i) state_d = ST_IDLE;
                       else if (cur_hit || last_mb) state_d = ST_WAIT;
            ST_WAIT:   if (err_i) state_d = ST_IDLE;
                       else if (move_bit)
                           state_d = (hit && !win_gone) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // staging buffer and scan datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q    <= 1'b0;
            stg_id   <= '0;
            stg_ide  <= 1'b0;
            stg_rtr  <= 1'b0;
            in_fifo  <= 1'b0;
            idx      <= '0;
            hit      <= 1'b0;
            hit_fifo <= 1'b0;
            hit_idx  <= '0;
        end else begin
            crc_q <= crc_act_i;
            unique case (state_q)
                ST_IDLE: if (crc_start) begin
                    stg_id   <= rx_id_i;
                    stg_ide  <= rx_ide_i;
                    stg_rtr  <= rx_rtr_i;
                    in_fifo  <= fifo_en_i && !fifo_full_o;
                    idx      <= '0;
                    hit      <= 1'b0;
                    hit_fifo <= 1'b0;
                    hit_idx  <= '0;
                end
                ST_SCAN: if (!err_i) begin
                    if (cur_hit) begin
                        hit      <= 1'b1;
                        hit_fifo <= in_fifo;
                        hit_idx  <= idx;
                    end else if (in_fifo && idx == TBL_LAST) begin
                        in_fifo <= 1'b0;
                        idx     <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_WAIT: if (win_gone) hit <= 1'b0;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        commit        = (state_q == ST_COMMIT);
        movein_o      = commit;
        movein_fifo_o = hit_fifo;
        movein_idx_o  = hit_idx;
        movein_id_o   = stg_id;
    end

    rxm_flags #(
        .NUM_MB    (NUM_MB),
        .FIFO_DEPTH(FIFO_DEPTH),
        .IDX_W     (IDX_W)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .commit_fifo(hit_fifo),
        .commit_idx (hit_idx),
        .fifo_pop   (fifo_pop_i),
        .mb_clr     (mb_flag_clr_i),
        .mb_flag    (mb_flag_o),
        .fifo_avail (fifo_avail_o),
        .fifo_full  (fifo_full_o)
    );
endmodule

// File: rtl/rxm_router_chk.sv
module rxm_router_chk #(
    parameter int NUM_MB       = 8,
    parameter int IDX_W        = 3,
    parameter int EOF_MOVE_BIT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eof_act_i,
    input logic [2:0]        eof_cnt_i,
    input logic              err_i,
    input logic              movein_o,
    input logic              movein_fifo_o,
    input logic [IDX_W-1:0]  movein_idx_o,
    input logic [NUM_MB-1:0] mb_flag_o,
    input logic              fifo_avail_o,
    input logic              fifo_full_o
);
    localparam logic [2:0] MOVE_CNT = 3'(EOF_MOVE_BIT);

    // R6
    movein_on_eof_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        movein_o |-> $past(eof_act_i && (eof_cnt_i == MOVE_CNT)));

    // R7
    error_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> !movein_o);

    // R4
    fifo_room_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (movein_o && movein_fifo_o) |-> !fifo_full_o);

    // R10
    mb_flag_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (movein_o && !movein_fifo_o) |=> mb_flag_o[$past(movein_idx_o)]);

    // R11
    full_implies_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_o |-> fifo_avail_o);
endmodule

bind rxm_router rxm_router_chk #(
    .NUM_MB      (NUM_MB),
    .IDX_W       (IDX_W),
    .EOF_MOVE_BIT(EOF_MOVE_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .eof_act_i    (eof_act_i),
    .eof_cnt_i    (eof_cnt_i),
    .err_i        (err_i),
    .movein_o     (movein_o),
    .movein_fifo_o(movein_fifo_o),
    .movein_idx_o (movein_idx_o),
    .mb_flag_o    (mb_flag_o),
    .fifo_avail_o (fifo_avail_o),
    .fifo_full_o  (fifo_full_o)
);

// File: tb/rxm_router_tb.sv
`timescale 1ns/1ps
module rxm_router_tb;
    localparam int NMB = 8;
    localparam int IW  = 29;
    localparam int NT  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [IW-1:0]     rx_id = '0;
    logic              rx_ide = 0, rx_rtr = 0, self_tx = 0, self_dis = 0;
    logic              crc_act = 0, eof_act = 0, err = 0, fifo_en = 0, fifo_pop = 0;
    logic [2:0]        eof_cnt = '0;
    logic [NT*IW-1:0]  tbl_id = '0, tbl_mask = '0;
    logic [NT-1:0]     tbl_ide = '0, tbl_rtr = '0;
    logic [NMB-1:0]    mb_en = '0, mb_ide = '0, mb_rtr = '0, mb_clr = '0;
    logic [NMB*IW-1:0] mb_id = '0, mb_mask = '0;

    logic           movein, movein_fifo, fifo_avail, fifo_full;
    logic [2:0]     movein_idx;
    logic [IW-1:0]  movein_id;
    logic [NMB-1:0] mb_flag;

    rxm_router u_dut (
        .clk(clk), .rst_n(rst_n), .rx_id_i(rx_id), .rx_ide_i(rx_ide), .rx_rtr_i(rx_rtr),
        .self_tx_i(self_tx), .self_rx_dis_i(self_dis), .crc_act_i(crc_act),
        .eof_act_i(eof_act), .eof_cnt_i(eof_cnt), .err_i(err), .fifo_en_i(fifo_en),
        .fifo_pop_i(fifo_pop), .tbl_id_i(tbl_id), .tbl_mask_i(tbl_mask),
        .tbl_ide_i(tbl_ide), .tbl_rtr_i(tbl_rtr), .mb_en_i(mb_en), .mb_id_i(mb_id),
        .mb_mask_i(mb_mask), .mb_ide_i(mb_ide), .mb_rtr_i(mb_rtr),
        .mb_flag_clr_i(mb_clr), .movein_o(movein), .movein_fifo_o(movein_fifo),
        .movein_idx_o(movein_idx), .movein_id_o(movein_id), .mb_flag_o(mb_flag),
        .fifo_avail_o(fifo_avail), .fifo_full_o(fifo_full)
    );

    typedef struct {
        bit            fifo;
        int            idx;
        logic [IW-1:0] id;
        string         tag;
    } exp_t;

    exp_t expq[$];
    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each move-in strobe against the queue head
    always @(negedge clk) begin
        if (rst_n && movein) begin
            if (expq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R6 unexpected move-in actual=%0d expected=none", movein_idx);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk({e.tag, " dest fifo"}, int'(movein_fifo), int'(e.fifo));
                chk({e.tag, " dest idx"}, int'(movein_idx), e.idx);
                chk({e.tag, " R1 stored id"}, int'(movein_id), int'(e.id));
            end
        end
    end

    task automatic set_mb(input int i, input logic [IW-1:0] id, input logic [IW-1:0] msk,
                          input logic ide, input logic rtr, input logic en);
        mb_id[i*IW +: IW] = id;
        mb_mask[i*IW +: IW] = msk;
        mb_ide[i] = ide;
        mb_rtr[i] = rtr;
        mb_en[i] = en;
    endtask

    task automatic set_tbl(input int k, input logic [IW-1:0] id, input logic [IW-1:0] msk);
        tbl_id[k*IW +: IW] = id;
        tbl_mask[k*IW +: IW] = msk;
        tbl_ide[k] = 1'b0;
        tbl_rtr[k] = 1'b0;
    endtask

    // driver: queues the expectation, then plays one frame's phases
    task automatic frame(input logic [IW-1:0] id, input logic ide, input logic rtr,
                         input bit want, input bit to_fifo, input int idx,
                         input bit with_err, input int deact, input string tag);
        if (want) begin
            exp_t e;
            e.fifo = to_fifo; e.idx = idx; e.id = id; e.tag = tag;
            expq.push_back(e);
        end
        @(negedge clk);
        rx_id = id; rx_ide = ide; rx_rtr = rtr; crc_act = 1'b1;
        @(negedge clk);
        rx_id = 29'h0ACE_5555;  // staging must have captured already
        repeat (24) @(negedge clk);
        crc_act = 1'b0;
        if (deact >= 0) mb_en[deact] = 1'b0;
        for (int c = 0; c < 7; c++) begin
            eof_act = 1'b1;
            eof_cnt = 3'(c);
            err = with_err && (c == 3);
            @(negedge clk);
        end
        eof_act = 1'b0; err = 1'b0; eof_cnt = '0;
        repeat (4) @(negedge clk);
        chk({tag, " queue drained"}, expq.size(), 0);
        expq.delete();
    endtask

    task automatic pulse_pop();
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NT; k++) set_tbl(k, 29'h555, 29'h7FF);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R6 reset movein", int'(movein), 0);
        chk("R10 reset flags", int'(mb_flag), 0);
        chk("R11 reset avail", int'(fifo_avail), 0);
        chk("R11 reset full", int'(fifo_full), 0);

        // R2 exact standard match
        set_mb(3, 29'h123, 29'h7FF, 0, 0, 1);
        frame(29'h123, 0, 0, 1, 0, 3, 0, -1, "R2 exact");
        chk("R10 flag set", int'(mb_flag), 32'h08);

        // R2 masked extended match, real ID stored
        set_mb(5, 29'h1ABC_DE00, 29'h1FFF_FF00, 1, 0, 1);
        frame(29'h1ABC_DE5A, 1, 0, 1, 0, 5, 0, -1, "R2 masked");

        // R2 IDE and RTR mismatch
        frame(29'h123, 1, 0, 0, 0, 0, 0, -1, "R2 ide mismatch");
        frame(29'h123, 0, 1, 0, 0, 0, 0, -1, "R2 rtr mismatch");

        // R5 lowest index wins
        set_mb(1, 29'h120, 29'h7F0, 0, 0, 1);
        frame(29'h123, 0, 0, 1, 0, 1, 0, -1, "R5 priority");

        // R9 disabled mailbox skipped, deactivated winner loses frame
        mb_en[1] = 1'b0;
        frame(29'h123, 0, 0, 1, 0, 3, 0, -1, "R9 skip");
        frame(29'h123, 0, 0, 0, 0, 0, 0, 3, "R9 lost");
        mb_en[3] = 1'b1;

        // R10 clear
        mb_clr = '1;
        @(negedge clk);
        mb_clr = '0;
        @(negedge clk);
        chk("R10 clear", int'(mb_flag), 0);

        // R8 self reception
        self_tx = 1; self_dis = 1;
        frame(29'h123, 0, 0, 0, 0, 0, 0, -1, "R8 suppressed");
        chk("R8 no flag", int'(mb_flag), 0);
        self_dis = 0;
        frame(29'h123, 0, 0, 1, 0, 3, 0, -1, "R8 allowed");
        self_tx = 0;
        mb_clr = '1;
        @(negedge clk);
        mb_clr = '0;

        // R7 error cancels
        frame(29'h123, 0, 0, 0, 0, 0, 1, -1, "R7 error");
        chk("R7 no flag", int'(mb_flag), 0);

        // R3 FIFO table first, lowest entry wins
        fifo_en = 1;
        set_tbl(2, 29'h123, 29'h7FF);
        set_tbl(5, 29'h123, 29'h7FF);
        frame(29'h123, 0, 0, 1, 1, 2, 0, -1, "R3 fifo first");
        chk("R11 avail", int'(fifo_avail), 1);
        chk("R3 no mb flag", int'(mb_flag), 0);
        for (int n = 0; n < 5; n++) frame(29'h123, 0, 0, 1, 1, 2, 0, -1, "R11 fill");
        chk("R11 full", int'(fifo_full), 1);

        // R4 full FIFO skipped
        frame(29'h123, 0, 0, 1, 0, 3, 0, -1, "R4 full skip");
        chk("R4 still full", int'(fifo_full), 1);

        // R11 pop releases one frame
        pulse_pop();
        chk("R11 pop not full", int'(fifo_full), 0);
        chk("R11 pop avail", int'(fifo_avail), 1);
        frame(29'h123, 0, 0, 1, 1, 2, 0, -1, "R3 refill");
        for (int n = 0; n < 6; n++) pulse_pop();
        chk("R11 drained", int'(fifo_avail), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule